// File: doc/BRIEF.md
# Bit-band alias bus bridge

This bridge sits between one bus master and a 32-bit word-addressed memory or peripheral port. It recognises two alias windows. Every 32-bit word in an alias window stands for a single bit of a matching bit-band window. The bridge works out which downstream word and which bit an alias address names. It finds them by arithmetic on the address, so it needs no separate set or clear registers.

A write to an alias word becomes a locked read-modify-write downstream. The bridge reads the target word and changes the single bit. It then writes the word back while the lock output stays high, so no other master can slip a write in between and have it lost. A read from an alias word returns only the addressed bit. Any address outside both alias windows is forwarded unchanged as one downstream access.

Both sides use a request/ready handshake. The master holds its request and its fields until it sees a one-cycle ready pulse. The bridge holds its downstream request and fields until the downstream port asserts ready. For a downstream read, the port's read data is valid in the same cycle as its ready.

Top module: `bitband_bridge`

## Requirements
- R1: An address is an alias access when its bits above BAND_AW+5 match an alias base. The bases are 0x22000000 (paired with bit-band base 0x20000000) and 0x42000000 (paired with 0x40000000). Both bases are aligned to the window size. Any other address is not an alias access.
- R2: For an alias offset, bits [BAND_AW+4:5] give the byte offset B and bits [4:2] give the bit number N. The target word is band base + (B with bits [1:0] cleared). The target bit index is B[1:0]*8 + N.
- R3: An alias write forces the target bit to bit 0 of the lowest enabled byte lane of the write data. This is data bit 0 for a full-word write. Every other written data bit has no effect, and every other bit of the target word keeps its value.
- R4: A word-sized alias write and a byte-sized alias write whose enabled lane carries the same bit 0 give the same result.
- R5: An alias read returns the target bit in up_rdata bit 0 and zeros in bits [31:1]. It issues exactly one downstream read and no downstream write.
- R6: An alias write issues exactly one downstream read and then exactly one downstream write with all four byte enables set. dn_lock is high from the read through acceptance of the write-back and falls after it.
- R7: up_ready is a one-cycle pulse. It is never high while a downstream request is pending, and for an alias write it follows acceptance of the write-back.
- R8: A non-alias access becomes exactly one downstream access with the same direction, address, write data and byte enables, with dn_lock low. Its read data is returned unchanged. The downstream request and its fields stay stable until dn_ready.
- R9: Alias address bits [1:0] have no effect on the target word or bit.
- R10: While rst_n is low the sequencer returns to idle, with dn_req, dn_lock and up_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_req | input | 1 | Master request, held until up_ready |
| up_we | input | 1 | Master write (1) or read (0) |
| up_addr | input | 32 | Master byte address |
| up_wdata | input | 32 | Master write data |
| up_be | input | 4 | Master byte enables |
| up_ready | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Read data, valid with up_ready |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_be | output | 4 | Downstream byte enables |
| dn_lock | output | 1 | Keeps other masters off during read-modify-write |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ready |
| dn_ready | input | 1 | Downstream accepts the request |

## Verification
The assertions assume that the master keeps up_req and its fields steady from the request until the ready pulse, and that it issues a new request only after that pulse. They also assume that the downstream port raises dn_ready only while dn_req is high. The bench meets these conditions by driving every request through one task that holds all fields until it sees up_ready at a falling edge. Its memory model derives dn_ready from dn_req and a stall counter that is reloaded from an LFSR, so the stalls vary but never answer a request that is not there. The small bench configuration (BAND_AW of 4) lets the sweep cover every bit of both windows.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ARD,
    ST_AWR,
    ST_DONE
  } bb_state_e;

  // bit index inside the 32-bit word: byte_lo*8 + bit number
  function automatic logic [4:0] bb_bit_index(input logic [1:0] byte_lo,
                                              input logic [2:0] bitn);
    return {byte_lo, bitn};
  endfunction

  // lowest enabled byte lane; lane 0 when no lane is enabled
  function automatic logic [1:0] bb_low_lane(input logic [3:0] be);
    if (be[0]) return 2'd0;
    if (be[1]) return 2'd1;
    if (be[2]) return 2'd2;
    if (be[3]) return 2'd3;
    return 2'd0;
  endfunction

  // value an alias write forces into the target bit
  function automatic logic bb_set_value(input logic [31:0] wdata,
                                        input logic [3:0]  be);
    logic [1:0] lane;
    lane = bb_low_lane(be);
    return wdata[{lane, 3'b000}];
  endfunction

  // word with a single bit forced
  function automatic logic [31:0] bb_apply(input logic [31:0] word,
                                           input logic [4:0]  idx,
                                           input logic        val);
    logic [31:0] r;
    r = word;
    r[idx] = val;
    return r;
  endfunction

endpackage

// File: rtl/bb_window.sv
module bb_window
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter logic [31:0] BAND_BASE  = 32'h2000_0000,
  parameter int          BAND_AW    = 20
) (
  input  logic [31:0] addr,
  output logic        hit,
  output logic [31:0] word_addr,
  output logic [4:0]  bit_idx
);
  localparam int ALIAS_AW = BAND_AW + 5;

  logic [BAND_AW-1:0] byte_off;

  assign hit       = (addr[31:ALIAS_AW] == ALIAS_BASE[31:ALIAS_AW]);
  assign byte_off  = addr[ALIAS_AW-1:5];
  assign word_addr = BAND_BASE + (32'(byte_off) & ~32'd3);
  assign bit_idx   = bb_bit_index(byte_off[1:0], addr[4:2]);

endmodule

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter logic [31:0] ALIAS0_BASE = 32'h2200_0000,
  parameter logic [31:0] BAND0_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS1_BASE = 32'h4200_0000,
  parameter logic [31:0] BAND1_BASE  = 32'h4000_0000,
  parameter int          BAND_AW     = 20
) (
  input  logic [31:0] addr,
  output logic        hit,
  output logic [31:0] word_addr,
  output logic [4:0]  bit_idx
);
  localparam int N_WIN = 2;
  localparam logic [31:0] ALIAS_B [N_WIN] = '{ALIAS0_BASE, ALIAS1_BASE};
  localparam logic [31:0] BAND_B  [N_WIN] = '{BAND0_BASE, BAND1_BASE};

  logic [N_WIN-1:0] hit_v;
  logic [31:0]      word_v [N_WIN];
  logic [4:0]       bit_v  [N_WIN];

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    bb_window #(
      .ALIAS_BASE(ALIAS_B[g]),
      .BAND_BASE (BAND_B[g]),
      .BAND_AW   (BAND_AW)
    ) u_win (
      .addr     (addr),
      .hit      (hit_v[g]),
      .word_addr(word_v[g]),
      .bit_idx  (bit_v[g])
    );
  end

  assign hit       = |hit_v;
  assign word_addr = hit_v[1] ? word_v[1] : word_v[0];
  assign bit_idx   = hit_v[1] ? bit_v[1]  : bit_v[0];

endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        up_req,
  input  logic        up_we,
  input  logic [31:0] up_addr,
  input  logic [31:0] up_wdata,
  input  logic [3:0]  up_be,
  output logic        up_ready,
  output logic [31:0] up_rdata,
  input  logic        map_hit,
  input  logic [31:0] map_word,
  input  logic [4:0]  map_bit,
  output logic        dn_req,
  output logic        dn_we,
  output logic [31:0] dn_addr,
  output logic [31:0] dn_wdata,
  output logic [3:0]  dn_be,
  output logic        dn_lock,
  input  logic [31:0] dn_rdata,
  input  logic        dn_ready,
  output logic        ev_rmw_rd_acc,
  output logic        ev_rmw_wr_acc,
  output logic        ev_alias_rd_done
);
  bb_state_e   state;
  logic        q_we, q_alias, q_set;
  logic [31:0] q_addr, q_wdata, q_word, q_rdata;
  logic [3:0]  q_be;
  logic [4:0]  q_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q_we    <= 1'b0;
      q_alias <= 1'b0;
      q_set   <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_word  <= '0;
      q_rdata <= '0;
      q_be    <= '0;
      q_bit   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (up_req) begin
          q_we    <= up_we;
          q_addr  <= up_addr;
          q_wdata <= up_wdata;
          q_be    <= up_be;
          q_alias <= map_hit;
          q_word  <= map_word;
          q_bit   <= map_bit;
          q_set   <= bb_set_value(up_wdata, up_be);
          state   <= map_hit ? ST_ARD : ST_PASS;
        end
        ST_PASS: if (dn_ready) begin
          q_rdata <= dn_rdata;
          state   <= ST_DONE;
        end
        ST_ARD: if (dn_ready) begin
          if (q_we) begin
            q_wdata <= bb_apply(dn_rdata, q_bit, q_set);
            state   <= ST_AWR;
          end else begin
            q_rdata <= {31'd0, dn_rdata[q_bit]};
            state   <= ST_DONE;
          end
        end
        ST_AWR: if (dn_ready) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dn_req   = 1'b0;
    dn_we    = 1'b0;
    dn_addr  = q_word;
    dn_wdata = q_wdata;
    dn_be    = 4'hF;
    dn_lock  = 1'b0;
    unique case (state)
      ST_PASS: begin
        dn_req  = 1'b1;
        dn_we   = q_we;
        dn_addr = q_addr;
        dn_be   = q_be;
      end
      ST_ARD: begin
        dn_req  = 1'b1;
        dn_lock = q_we;
      end
      ST_AWR: begin
        dn_req  = 1'b1;
        dn_we   = 1'b1;
        dn_lock = 1'b1;
      end
      default: ;
    endcase
  end

  assign up_ready         = (state == ST_DONE);
  assign up_rdata         = q_rdata;
  assign ev_rmw_rd_acc    = (state == ST_ARD) && q_we && dn_ready;
  assign ev_rmw_wr_acc    = (state == ST_AWR) && dn_ready;
  assign ev_alias_rd_done = (state == ST_DONE) && q_alias && !q_we;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] ALIAS0_BASE = 32'h2200_0000,
  parameter logic [31:0] BAND0_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS1_BASE = 32'h4200_0000,
  parameter logic [31:0] BAND1_BASE  = 32'h4000_0000,
  parameter int          BAND_AW     = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        up_req,
  input  logic        up_we,
  input  logic [31:0] up_addr,
  input  logic [31:0] up_wdata,
  input  logic [3:0]  up_be,
  output logic        up_ready,
  output logic [31:0] up_rdata,
  output logic        dn_req,
  output logic        dn_we,
  output logic [31:0] dn_addr,
  output logic [31:0] dn_wdata,
  output logic [3:0]  dn_be,
  output logic        dn_lock,
  input  logic [31:0] dn_rdata,
  input  logic        dn_ready
);
  logic        map_hit;
  logic [31:0] map_word;
  logic [4:0]  map_bit;
  logic        ev_rmw_rd_acc;
  logic        ev_rmw_wr_acc;
  logic        ev_alias_rd_done;

  bb_decode #(
    .ALIAS0_BASE(ALIAS0_BASE),
    .BAND0_BASE (BAND0_BASE),
    .ALIAS1_BASE(ALIAS1_BASE),
    .BAND1_BASE (BAND1_BASE),
    .BAND_AW    (BAND_AW)
  ) u_decode (
    .addr     (up_addr),
    .hit      (map_hit),
    .word_addr(map_word),
    .bit_idx  (map_bit)
  );

  bb_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .up_req          (up_req),
    .up_we           (up_we),
    .up_addr         (up_addr),
    .up_wdata        (up_wdata),
    .up_be           (up_be),
    .up_ready        (up_ready),
    .up_rdata        (up_rdata),
    .map_hit         (map_hit),
    .map_word        (map_word),
    .map_bit         (map_bit),
    .dn_req          (dn_req),
    .dn_we           (dn_we),
    .dn_addr         (dn_addr),
    .dn_wdata        (dn_wdata),
    .dn_be           (dn_be),
    .dn_lock         (dn_lock),
    .dn_rdata        (dn_rdata),
    .dn_ready        (dn_ready),
    .ev_rmw_rd_acc   (ev_rmw_rd_acc),
    .ev_rmw_wr_acc   (ev_rmw_wr_acc),
    .ev_alias_rd_done(ev_alias_rd_done)
  );

endmodule

// File: rtl/bb_checks.sv
module bb_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        up_ready,
  input logic [31:0] up_rdata,
  input logic        dn_req,
  input logic        dn_we,
  input logic [31:0] dn_addr,
  input logic [31:0] dn_wdata,
  input logic [3:0]  dn_be,
  input logic        dn_lock,
  input logic        dn_ready,
  input logic        ev_rmw_rd_acc,
  input logic        ev_rmw_wr_acc,
  input logic        ev_alias_rd_done
);
  p_lock_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_rd_acc |=> dn_lock && dn_req && dn_we);

  p_lock_full_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_lock && dn_we |-> dn_be == 4'hF);

  p_lock_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_wr_acc |=> !dn_lock);

  p_ready_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_wr_acc |=> up_ready);

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);

  p_no_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !up_ready);

  p_alias_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alias_rd_done |-> up_ready && (up_rdata[31:1] == 31'd0));

  p_dn_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ready |=> dn_req && $stable(dn_addr) && $stable(dn_we)
                            && $stable(dn_wdata) && $stable(dn_be));

  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> !dn_req && !dn_lock && !up_ready);

endmodule

bind bitband_bridge bb_checks u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .up_ready        (up_ready),
  .up_rdata        (up_rdata),
  .dn_req          (dn_req),
  .dn_we           (dn_we),
  .dn_addr         (dn_addr),
  .dn_wdata        (dn_wdata),
  .dn_be           (dn_be),
  .dn_lock         (dn_lock),
  .dn_ready        (dn_ready),
  .ev_rmw_rd_acc   (ev_rmw_rd_acc),
  .ev_rmw_wr_acc   (ev_rmw_wr_acc),
  .ev_alias_rd_done(ev_alias_rd_done)
);

// File: tb/bitband_bridge_bench.sv
module bitband_bridge_bench;
  localparam int          BAW = 4;
  localparam logic [31:0] AB0 = 32'h2200_0000;
  localparam logic [31:0] BB0 = 32'h2000_0000;
  localparam logic [31:0] AB1 = 32'h4200_0000;
  localparam logic [31:0] BB1 = 32'h4000_0000;
  localparam int          NBYTES = 1 << BAW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req = 1'b0, up_we = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [3:0]  up_be = '0;
  logic        up_ready;
  logic [31:0] up_rdata;
  logic        dn_req, dn_we, dn_lock, dn_ready;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;
  logic [3:0]  dn_be;

  always #2.5 clk = ~clk;

  bitband_bridge #(.ALIAS0_BASE(AB0), .BAND0_BASE(BB0), .ALIAS1_BASE(AB1),
                   .BAND1_BASE(BB1), .BAND_AW(BAW)) u_bitband_bridge (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
    .up_wdata(up_wdata), .up_be(up_be), .up_ready(up_ready), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_be(dn_be), .dn_lock(dn_lock), .dn_rdata(dn_rdata), .dn_ready(dn_ready));

  // downstream memory model with varying stalls
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_mem [logic [31:0]];
  logic [1:0]  stall = 2'd0;
  logic [7:0]  lfsr = 8'hA5;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = be[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  assign dn_ready = dn_req && (stall == 2'd0);
  assign dn_rdata = mem_rd(dn_addr);

  // per-transaction downstream record
  int          n_rd, n_wr, n_unlocked;
  logic        last_we;
  logic [31:0] last_addr, last_wdata;
  logic [3:0]  last_be;

  always @(posedge clk) begin
    if (rst_n && dn_req) begin
      if (dn_ready) begin
        if (dn_we) begin
          mem[dn_addr] = merge(mem_rd(dn_addr), dn_wdata, dn_be);
          n_wr++;
        end else n_rd++;
        if (!dn_lock) n_unlocked++;
        last_we = dn_we; last_addr = dn_addr; last_wdata = dn_wdata; last_be = dn_be;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        stall <= lfsr[1:0];
      end else stall <= stall - 2'd1;
    end
  end

  int n_chk = 0, n_fail = 0;
  logic timed_out = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd);
    int t;
    @(negedge clk);
    n_rd = 0; n_wr = 0; n_unlocked = 0;
    up_req = 1'b1; up_we = we; up_addr = a; up_wdata = d; up_be = be;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!up_ready && t < 100);
    if (!up_ready) timed_out = 1'b1;
    rd = up_rdata;
    up_req = 1'b0;
  endtask

  function automatic logic [31:0] tgt_word(input logic [31:0] ab, input logic [31:0] bb,
                                           input logic [31:0] a);
    int b;
    b = int'((a - ab) >> 5);
    return bb + 32'((b / 4) * 4);
  endfunction
  function automatic int tgt_bit(input logic [31:0] ab, input logic [31:0] a);
    int b;
    b = int'((a - ab) >> 5);
    return (b % 4) * 8 + int'((a >> 2) & 32'd7);
  endfunction

  initial begin : wd
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    n_fail++; n_chk++;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] rd, wa, a, d, ew;
    logic [31:0] ab, bb;
    int i, bi, lane;
    logic v;
    mem.delete(); exp_mem.delete();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!up_ready && !dn_req && !dn_lock, "R10 reset idle",
          {29'd0, up_ready, dn_req, dn_lock}, 32'd0);
    rst_n = 1'b1;

    // R8: preload band words by pass-through writes, check forwarded fields
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < NBYTES / 4; k++) begin
        wa = (w == 0 ? BB0 : BB1) + 32'(k * 4);
        d  = 32'h9E37_79B9 * (wa + 1);
        xfer(1'b1, wa, d, 4'hF, rd);
        exp_mem[wa] = d;
        check(n_wr == 1 && n_rd == 0 && n_unlocked == 1 && last_addr == wa &&
              last_wdata == d && last_be == 4'hF, "R8 pass write fields", last_addr, wa);
      end
    end

    // sweep every bit of both windows
    i = 0;
    for (int w = 0; w < 2; w++) begin
      ab = (w == 0) ? AB0 : AB1;
      bb = (w == 0) ? BB0 : BB1;
      for (int by = 0; by < NBYTES; by++) begin
        for (int bn = 0; bn < 8; bn++) begin
          a  = ab + 32'(by * 32) + 32'(bn * 4);
          wa = tgt_word(ab, bb, a);
          bi = tgt_bit(ab, a);
          v  = logic'(((i * 7) >> 1) & 1);
          d  = 32'hDEAD_BEEF ^ (32'(i) << 8);
          lane = i % 4;
          // R3/R4/R9: word write, byte lane 0, or byte lane with low address bits
          case (i % 3)
            0: begin d[0] = v; xfer(1'b1, a, d, 4'hF, rd); end
            1: begin d[0] = v; xfer(1'b1, a, d, 4'h1, rd); end
            default: begin
              d[8*lane] = v;
              xfer(1'b1, a | 32'(lane), d, 4'(1 << lane), rd);
            end
          endcase
          ew = exp_rd(wa); ew[bi] = v; exp_mem[wa] = ew;
          check(mem_rd(wa) == ew, "R3 R4 R9 alias write target word", mem_rd(wa), ew);
          check(n_rd == 1 && n_wr == 1 && n_unlocked == 0 && last_be == 4'hF,
                "R6 locked rmw", 32'(n_rd * 16 + n_wr * 4 + n_unlocked), 32'h14);
          // R5/R2: alias read of the same bit, with junk low address bits (R9)
          xfer(1'b0, a | 32'((i + 1) % 4), 32'hFFFF_FFFF, 4'hF, rd);
          check(rd == {31'd0, ew[bi]}, "R5 R2 alias read bit", rd, {31'd0, ew[bi]});
          check(n_rd == 1 && n_wr == 0, "R5 alias read no write", 32'(n_wr), 32'd0);
          i++;
        end
        // R8: pass-through read of the band word returns it unchanged
        wa = bb + 32'((by / 4) * 4);
        xfer(1'b0, wa, 32'h0, 4'hF, rd);
        check(rd == exp_rd(wa), "R8 pass read band word", rd, exp_rd(wa));
      end
    end

    // R1: addresses just outside the alias windows pass through with byte enables
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: a = AB0 + 32'(1 << (BAW + 5));
        1: a = AB0 - 32'd4;
        2: a = AB1 + 32'(1 << (BAW + 5)) + 32'd8;
        default: a = 32'h3000_0010;
      endcase
      d = 32'h1234_5678 + 32'(k);
      xfer(1'b1, a, d, 4'(4'b0101 << (k % 2)), rd);
      exp_mem[a] = merge(exp_rd(a), d, 4'(4'b0101 << (k % 2)));
      check(n_wr == 1 && n_rd == 0 && last_addr == a && last_be == 4'(4'b0101 << (k % 2)),
            "R1 outside alias forwarded", last_addr, a);
      xfer(1'b0, a, 32'h0, 4'hF, rd);
      check(rd == exp_rd(a), "R1 R8 outside alias read", rd, exp_rd(a));
    end

    // R10: reset in the middle of an alias write drops the lock
    @(negedge clk);
    up_req = 1'b1; up_we = 1'b1; up_addr = AB0; up_wdata = 32'h1; up_be = 4'hF;
    @(negedge clk);
    rst_n = 1'b0; up_req = 1'b0;
    @(negedge clk);
    check(!dn_lock && !dn_req && !up_ready, "R10 reset mid rmw",
          {29'd0, up_ready, dn_req, dn_lock}, 32'd0);
    rst_n = 1'b1;

    if (timed_out) check(1'b0, "handshake timeout", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule